// File: doc/BRIEF.md
# Pattern I/O Request Pacer

This block produces the request strobes that pace a parallel digital input group. Each strobe tells a downstream consumer that a fresh sample of the input word is ready. It also latches that full word into a capture register on the same clock edge as the strobe. Three request sources are available, chosen by a two-bit select:

- **Timer.** A timebase prescaler divides the system clock into one of six fixed tick periods. An interval counter then emits one request every `interval` ticks.
- **External.** Rising edges on an asynchronous request pin are synchronized, and each one becomes a single request.
- **Change.** A request is raised once whenever any input line enabled in the line mask takes a new value.

The consumer acknowledges each capture. If a new request arrives while the previous capture is still unacknowledged, a sticky overrun flag is set. In timer mode, an unsupported timebase code or an interval below two stops all requests and raises a configuration error flag. The block has no buffering, no DMA and no software access; it only paces and captures.

Top module: `pio_req_pacer`

## Requirements
- R1: After synchronous reset, `req`, `overrun` and `cfg_err` are 0 and `cap_data` is all zeros.
- R2: Source select encoding:
  - 0 selects the internal timer.
  - 1 selects the external request pin.
  - 2 selects input change detection.
  - 3 produces no requests at all.
- R3: The timebase code is a 4-bit two's-complement value with the following tick periods:
  - 4'hD (-3) gives 50 ns.
  - 1 gives 1 us.
  - 2 gives 10 us.
  - 3 gives 100 us.
  - 4 gives 1 ms.
  - 5 gives 10 ms.
  - Each tick period is converted to clock cycles using `CLK_HZ`. At the default of 20 MHz these are 1, 20, 200, 2000, 20000 and 200000 cycles.
- R4: In timer mode, consecutive requests are exactly (tick cycles x interval) clock cycles apart, for any interval from 2 to 65535. For example, code 2 with interval 10 gives 100 us, which is 2000 cycles at 20 MHz.
- R5: In timer mode, any timebase code not listed in R3, or an interval of 0 or 1, causes the following:
  - No requests are issued.
  - `cfg_err` reads 1 from the cycle after the bad setting appears.
  - `cfg_err` is 0 whenever the timer setting is legal or another source is selected.
- R6: In external mode, the pin passes through a two-stage synchronizer. Each rising edge gives exactly one request, visible three clock edges after the pin rises. Falling edges and steady levels give none.
- R7: In change mode, only lines whose `line_mask` bit is 1 are compared. A change confined to lines whose mask bit is 0 issues no request.
- R8: On every request, `cap_data` takes the whole input word present at that edge, including lines whose mask bit is 0. It holds that value until the next request.
- R9: In change mode, exactly one request is issued per new input pattern. An input word that stays constant issues no further requests.
- R10: Overrun behaviour:
  - `overrun` becomes 1 on the edge of a request that arrives while the previous capture is unacknowledged, and it stays 1 until reset.
  - A 1 on `ack` acknowledges the outstanding capture.
  - An `ack` on the same cycle as a new request counts as acknowledging the previous capture, so no overrun is raised.
- R11: `req` is a registered single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at `CLK_HZ` |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Request source (R2 encoding) |
| tb_code | input | 4 | Timebase code, two's complement (R3) |
| interval | input | IVW | Ticks between timer requests |
| line_mask | input | W | 1 = line compared in change mode |
| din | input | W | Group input word, synchronous to `clk` |
| ext_req | input | 1 | Asynchronous external request pin |
| ack | input | 1 | Consumer acknowledge of the current capture |
| req | output | 1 | Request strobe |
| cap_data | output | W | Input word captured with the last request |
| overrun | output | 1 | Sticky: request arrived before acknowledge |
| cfg_err | output | 1 | Illegal timer setting while timer source selected |

## Verification
The assertions take for granted that `din`, `line_mask` and the configuration inputs are synchronous to `clk`. Only `ext_req` may change at any time. They also rely on the rule that a rising edge on the synchronizer output can never appear on two cycles in a row. The timer checks further assume that a fired interval counter needs at least two ticks before it fires again, which the interval floor of two guarantees.

The bench drives every input just after a falling clock edge and keeps `ext_req` high and low for several cycles at a time. It changes the configuration only under reset or between measured request gaps, so every timer gap it samples comes from a stable setting.

// File: rtl/pio_pacer_pkg.sv
package pio_pacer_pkg;

  typedef enum logic [1:0] {
    SRC_TIMER  = 2'd0,
    SRC_EXT    = 2'd1,
    SRC_CHANGE = 2'd2,
    SRC_NONE   = 2'd3
  } src_e;

  // Timebase codes (two's complement in 4 bits).
  localparam logic [3:0] TB_50NS  = 4'hD;
  localparam logic [3:0] TB_1US   = 4'h1;
  localparam logic [3:0] TB_10US  = 4'h2;
  localparam logic [3:0] TB_100US = 4'h3;
  localparam logic [3:0] TB_1MS   = 4'h4;
  localparam logic [3:0] TB_10MS  = 4'h5;

endpackage

// File: rtl/pacer_timebase.sv
module pacer_timebase
  import pio_pacer_pkg::*;
#(
  parameter int CLK_HZ = 20_000_000,
  parameter int IVW    = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sel,
  input  logic [3:0]     code,
  input  logic [IVW-1:0] interval,
  output logic           fire,
  output logic           bad_cfg
);
  localparam int MAXDIV = CLK_HZ / 100;
  localparam int PW     = $clog2(MAXDIV + 1);

  logic [PW-1:0]  div_m1;
  logic           code_ok;
  logic           run;
  logic           tick;
  logic [PW-1:0]  pcnt;
  logic [IVW-1:0] icnt;

  always_comb begin
    code_ok = 1'b1;
    case (code)
      TB_50NS:  div_m1 = PW'(CLK_HZ / 20_000_000 - 1);
      TB_1US:   div_m1 = PW'(CLK_HZ / 1_000_000 - 1);
      TB_10US:  div_m1 = PW'(CLK_HZ / 100_000 - 1);
      TB_100US: div_m1 = PW'(CLK_HZ / 10_000 - 1);
      TB_1MS:   div_m1 = PW'(CLK_HZ / 1_000 - 1);
      TB_10MS:  div_m1 = PW'(CLK_HZ / 100 - 1);
      default: begin
        div_m1  = '0;
        code_ok = 1'b0;
      end
    endcase
  end

  assign bad_cfg = sel && (!code_ok || interval < IVW'(2));
  assign run     = sel && !bad_cfg;
  assign tick    = run && (pcnt >= div_m1);
  assign fire    = tick && (icnt >= interval - IVW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt <= '0;
      icnt <= '0;
    end else begin
      pcnt <= tick ? '0 : pcnt + PW'(1);
      if (tick) icnt <= fire ? '0 : icnt + IVW'(1);
    end
  end

  // R4
  timer_gap_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);

  // R5
  timer_bad_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    bad_cfg |-> !fire);

endmodule

// File: rtl/pacer_ext_edge.sv
module pacer_ext_edge (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fire
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign fire = sync_q && !last_q;

  // R6
  ext_single_edge_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);

endmodule

// File: rtl/pacer_change_det.sv
module pacer_change_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] din,
  input  logic [W-1:0] mask,
  output logic         fire
);
  logic [W-1:0] prev_q;

  // Tracks the input every cycle, so entering change mode never fires on stale history.
  always_ff @(posedge clk) prev_q <= din;

  assign fire = |((din ^ prev_q) & mask);

endmodule

// File: rtl/pio_req_pacer.sv
module pio_req_pacer
  import pio_pacer_pkg::*;
#(
  parameter int CLK_HZ = 20_000_000,
  parameter int W      = 8,
  parameter int IVW    = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     src_sel,
  input  logic [3:0]     tb_code,
  input  logic [IVW-1:0] interval,
  input  logic [W-1:0]   line_mask,
  input  logic [W-1:0]   din,
  input  logic           ext_req,
  input  logic           ack,
  output logic           req,
  output logic [W-1:0]   cap_data,
  output logic           overrun,
  output logic           cfg_err
);
  src_e src;
  logic fire_tmr, fire_ext, fire_chg, fire, bad_cfg;
  logic pend_q;

  assign src = src_e'(src_sel);

  pacer_timebase #(.CLK_HZ(CLK_HZ), .IVW(IVW)) u_tmr (
    .clk(clk), .rst(rst), .sel(src == SRC_TIMER), .code(tb_code),
    .interval(interval), .fire(fire_tmr), .bad_cfg(bad_cfg)
  );

  pacer_ext_edge u_ext (
    .clk(clk), .rst(rst), .pin(ext_req), .fire(fire_ext)
  );

  pacer_change_det #(.W(W)) u_chg (
    .clk(clk), .din(din), .mask(line_mask), .fire(fire_chg)
  );

  always_comb begin
    case (src)
      SRC_TIMER:  fire = fire_tmr;
      SRC_EXT:    fire = fire_ext;
      SRC_CHANGE: fire = fire_chg;
      default:    fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req      <= 1'b0;
      cap_data <= '0;
      overrun  <= 1'b0;
      cfg_err  <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      req     <= fire;
      cfg_err <= bad_cfg;
      if (fire) begin
        cap_data <= din;
        pend_q   <= 1'b1;
        if (pend_q && !ack) overrun <= 1'b1;
      end else if (ack) begin
        pend_q <= 1'b0;
      end
    end
  end

  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  // R10
  overrun_with_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> req);

  // R5
  cfg_err_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !req);

  // R2
  src_none_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_NONE) |=> !req);

endmodule

// File: tb/sim_pio_req_pacer.sv
module sim_pio_req_pacer;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  src_sel;
  logic [3:0]  tb_code;
  logic [15:0] interval;
  logic [7:0]  line_mask, din;
  logic        ext_req, ack;
  logic        req, overrun, cfg_err;
  logic [7:0]  cap_data;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk; // 50 MHz; timebase counts in cycles at CLK_HZ

  pio_req_pacer u0 (
    .clk(clk), .rst(rst), .src_sel(src_sel), .tb_code(tb_code),
    .interval(interval), .line_mask(line_mask), .din(din),
    .ext_req(ext_req), .ack(ack), .req(req), .cap_data(cap_data),
    .overrun(overrun), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; src_sel = 2'd3; tb_code = 4'h1; interval = 16'd2;
    line_mask = 8'h00; din = 8'h00; ext_req = 1'b0; ack = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic count_reqs(input int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (req) cnt++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    check(req == 0 && overrun == 0 && cfg_err == 0, "R1 flags", {req, overrun, cfg_err}, 0);
    check(cap_data == 0, "R1 cap_data", cap_data, 0);
  endtask

  task automatic t_timer_gap(input logic [3:0] code, input logic [15:0] iv, input int exp);
    int n;
    int g;
    do_reset();
    din = 8'hA5; tb_code = code; interval = iv; src_sel = 2'd0;
    n = 0;
    while (!req && n < 100000) begin @(negedge clk); n++; end
    check(req == 1, "R4 first request", req, 1);
    check(cap_data == 8'hA5, "R8 timer capture", cap_data, 8'hA5);
    g = 0;
    do begin @(negedge clk); g++; end while (!req && g < 100000);
    check(g == exp, "R3 R4 request gap", g, exp);
    check(cfg_err == 0, "R5 legal no error", cfg_err, 0);
  endtask

  task automatic t_bad_cfg(input logic [3:0] code, input logic [15:0] iv);
    int c;
    do_reset();
    tb_code = code; interval = iv; src_sel = 2'd0;
    count_reqs(300, c);
    check(c == 0, "R5 no requests", c, 0);
    check(cfg_err == 1, "R5 cfg_err", cfg_err, 1);
    src_sel = 2'd2;
    @(negedge clk);
    check(cfg_err == 0, "R5 clears in other mode", cfg_err, 0);
  endtask

  task automatic t_external();
    int c;
    do_reset();
    src_sel = 2'd1;
    repeat (3) @(negedge clk);
    ext_req = 1'b1;
    @(negedge clk); check(req == 0, "R6 latency e1", req, 0);
    @(negedge clk); check(req == 0, "R6 latency e2", req, 0);
    @(negedge clk); check(req == 1, "R6 latency e3", req, 1);
    @(negedge clk); check(req == 0, "R11 single pulse", req, 0);
    count_reqs(6, c);
    check(c == 0, "R6 steady high", c, 0);
    c = 0;
    for (int k = 0; k < 4; k++) begin
      int cc;
      ext_req = 1'b0; count_reqs(5, cc); c += cc;
      ext_req = 1'b1; count_reqs(5, cc); c += cc;
    end
    ext_req = 1'b0; begin int cc; count_reqs(8, cc); c += cc; end
    check(c == 4, "R6 one per rising edge", c, 4);
  endtask

  task automatic t_change();
    int c;
    do_reset();
    line_mask = 8'h0F; src_sel = 2'd2;
    repeat (3) @(negedge clk);
    din = 8'h30;
    count_reqs(5, c);
    check(c == 0, "R7 masked-out change ignored", c, 0);
    check(cap_data == 8'h00, "R7 capture untouched", cap_data, 0);
    din = 8'h31;
    @(negedge clk);
    check(req == 1, "R7 masked change fires", req, 1);
    check(cap_data == 8'h31, "R8 full word captured", cap_data, 8'h31);
    count_reqs(10, c);
    check(c == 0, "R9 held pattern quiet", c, 0);
    din = 8'h32; @(negedge clk); din = 8'h33; @(negedge clk);
    check(req == 1 && cap_data == 8'h33, "R9 back-to-back patterns", cap_data, 8'h33);
  endtask

  task automatic t_overrun();
    do_reset();
    line_mask = 8'hFF; src_sel = 2'd2; ack = 1'b0;
    repeat (2) @(negedge clk);
    din = 8'h01; @(negedge clk);
    check(overrun == 0, "R10 first request no overrun", overrun, 0);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    din = 8'h02; @(negedge clk);
    check(overrun == 0, "R10 acked no overrun", overrun, 0);
    repeat (2) @(negedge clk);
    din = 8'h03; @(negedge clk);
    check(overrun == 1, "R10 unacked overrun", overrun, 1);
    ack = 1'b1; repeat (4) @(negedge clk);
    check(overrun == 1, "R10 sticky", overrun, 1);
    do_reset();
    line_mask = 8'hFF; src_sel = 2'd2; ack = 1'b0;
    repeat (2) @(negedge clk);
    din = 8'h04; @(negedge clk);
    ack = 1'b1; din = 8'h05; @(negedge clk);
    check(overrun == 0, "R10 ack with new request", overrun, 0);
  endtask

  task automatic t_src_none();
    int c;
    do_reset();
    line_mask = 8'hFF; src_sel = 2'd3; tb_code = 4'hD; interval = 16'd2;
    repeat (2) @(negedge clk);
    din = 8'h77; ext_req = 1'b1;
    count_reqs(20, c);
    check(c == 0, "R2 source 3 silent", c, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_timer_gap(4'hD, 16'd2, 2);
    t_timer_gap(4'hD, 16'd7, 7);
    t_timer_gap(4'h1, 16'd3, 60);
    t_timer_gap(4'h2, 16'd10, 2000);
    t_timer_gap(4'h3, 16'd2, 4000);
    t_timer_gap(4'h4, 16'd2, 40000);
    t_bad_cfg(4'h0, 16'd5);
    t_bad_cfg(4'h6, 16'd5);
    t_bad_cfg(4'hD, 16'd1);
    t_external();
    t_change();
    t_overrun();
    t_src_none();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule